// File: doc/BRIEF.md
# Shared Writeback Port Arbiter with Operand Forwarding

This block sits between two producers of register results and a single register-file write port. One producer is a multicycle floating-point unit, the other is the integer ALU. Whenever both offer a result in the same cycle, the floating-point result takes the port. The ALU result moves into a one-entry hold register and is written on the next cycle in which the floating-point unit leaves the port free.

The block also supplies the two operands that the decode stage reads. Each operand is the register-file value unless a newer value is in flight. A newer value can be the ALU result of this cycle, the ALU result waiting in the hold register, or the floating-point result being written this cycle. Covering the held result is what keeps an indirect jump, decoded in the cycle after a port collision, from jumping through a stale base register. A dependent ALU-then-jump pair therefore computes the same target whether or not it collided with a floating-point writeback.

When the hold register is full, the floating-point unit claims the port and the ALU offers another result, the block raises a stall. The ALU must present the same result again on the next cycle, so nothing is lost.

Top module: `wbf_top`

## Requirements
- R1: When the floating-point unit requests the port (valid, destination not 0), the write port carries its destination and data in that same cycle, whatever the ALU or the hold register offer.
- R2: An ALU request that meets a floating-point request while the hold register is empty is not written in that cycle. It is written, with unchanged destination and data, in the first later cycle in which the floating-point unit does not request the port.
- R3: An ALU request with no floating-point request and an empty hold register is written through the port in the same cycle.
- R4: A decode read whose address matches the held ALU entry returns the held data, unless the ALU of the current cycle targets the same register. This holds also in the cycle the held entry drains to the port.
- R5: For each operand the forwarding order is: current ALU request, then the held ALU entry, then the current floating-point request, then the register-file read data.
- R6: A read of address 0 returns zero. A request whose destination is 0 is discarded: it neither writes the port nor takes the hold register.
- R7: The stall output is high exactly when the hold register is full, the floating-point unit requests the port and the ALU makes a request. While stalled, the hold register keeps its entry and the ALU request is not accepted.
- R8: When the held entry and a newer ALU result target the same register, the held entry is written first and the newer one later, so the newer value is what the register file finally holds.
- R9: Reset empties the hold register. The first cycle after reset, with no requests, writes nothing and does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_vld | input | 1 | ALU offers a result this cycle |
| alu_rd | input | AW | ALU destination register |
| alu_data | input | DW | ALU result |
| fpu_vld | input | 1 | Floating-point unit offers a result this cycle |
| fpu_rd | input | AW | Floating-point destination register |
| fpu_data | input | DW | Floating-point result |
| rd_addr_a | input | AW | Decode read address, operand A (jump base) |
| rd_addr_b | input | AW | Decode read address, operand B |
| rf_rdata_a | input | DW | Register-file read data for operand A |
| rf_rdata_b | input | DW | Register-file read data for operand B |
| wp_en | output | 1 | Register-file write enable |
| wp_addr | output | AW | Register-file write address |
| wp_data | output | DW | Register-file write data |
| opnd_a | output | DW | Forwarded operand A |
| opnd_b | output | DW | Forwarded operand B |
| stall | output | 1 | ALU request not accepted this cycle |

## Verification
The write port, the stall flag and both operands are combinational functions of the current requests and the hold register. They are therefore due in the very cycle the stimulus is applied. A deferred ALU result shows up on the port one clock edge after the collision at the earliest, and later if the floating-point unit keeps the port. The bench drives each vector on the falling edge and samples every output 2 ns later, before the next rising edge. It lets exactly one rising edge pass between vectors, so each held entry is seen on the port and on the operands in the cycle the requirements predict. A bench model of the register array, updated from the write port on each rising edge, supplies the read data. The final register contents after each collision are then checked through plain reads.

// File: rtl/wbf_pkg.sv
package wbf_pkg;

  // Source chosen for one forwarded operand.
  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_ALU,
    SRC_HOLD,
    SRC_FPU,
    SRC_RF
  } fwd_src_e;

  // Owner of the register-file write port in one cycle.
  typedef enum logic [1:0] {
    PORT_IDLE,
    PORT_FPU,
    PORT_HOLD,
    PORT_ALU
  } port_owner_e;

  // Forwarding order: newest producer first, register file last.
  function automatic fwd_src_e pick_src(input logic rd_zero,
                                        input logic alu_hit,
                                        input logic hold_hit,
                                        input logic fpu_hit);
    if (rd_zero)       return SRC_ZERO;
    else if (alu_hit)  return SRC_ALU;
    else if (hold_hit) return SRC_HOLD;
    else if (fpu_hit)  return SRC_FPU;
    else               return SRC_RF;
  endfunction

  // The FPU always wins; an older held ALU entry drains before a new one.
  function automatic port_owner_e pick_owner(input logic fpu_eff,
                                             input logic hold_vld,
                                             input logic alu_eff);
    if (fpu_eff)       return PORT_FPU;
    else if (hold_vld) return PORT_HOLD;
    else if (alu_eff)  return PORT_ALU;
    else               return PORT_IDLE;
  endfunction

endpackage

// File: rtl/wbf_port_arb.sv
module wbf_port_arb
  import wbf_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alu_eff,
  input  logic [AW-1:0] alu_rd,
  input  logic [DW-1:0] alu_data,
  input  logic          fpu_eff,
  input  logic [AW-1:0] fpu_rd,
  input  logic [DW-1:0] fpu_data,
  output logic          wp_en,
  output logic [AW-1:0] wp_addr,
  output logic [DW-1:0] wp_data,
  output logic          stall,
  output logic          hold_vld,
  output logic [AW-1:0] hold_rd,
  output logic [DW-1:0] hold_data
);

  port_owner_e owner;
  logic        hold_load;
  logic        hold_drain;

  assign owner = pick_owner(fpu_eff, hold_vld, alu_eff);
  assign stall = hold_vld && fpu_eff && alu_eff;

  // An accepted ALU request that does not own the port goes to the hold slot.
  assign hold_load  = alu_eff && !stall && (owner != PORT_ALU);
  assign hold_drain = (owner == PORT_HOLD);

  always_comb begin
    wp_en   = 1'b0;
    wp_addr = '0;
    wp_data = '0;
    unique case (owner)
      PORT_FPU:  begin wp_en = 1'b1; wp_addr = fpu_rd;  wp_data = fpu_data;  end
      PORT_HOLD: begin wp_en = 1'b1; wp_addr = hold_rd; wp_data = hold_data; end
      PORT_ALU:  begin wp_en = 1'b1; wp_addr = alu_rd;  wp_data = alu_data;  end
      default:   begin end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_rd   <= '0;
      hold_data <= '0;
    end else if (hold_load) begin
      hold_vld  <= 1'b1;
      hold_rd   <= alu_rd;
      hold_data <= alu_data;
    end else if (hold_drain) begin
      hold_vld  <= 1'b0;
    end
  end

  assert_fpu_owns_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fpu_eff |-> (wp_en && wp_addr == fpu_rd && wp_data == fpu_data));

  assert_collision_defers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_eff && fpu_eff && !hold_vld) |=>
      (hold_vld && hold_rd == $past(alu_rd) && hold_data == $past(alu_data)));

  assert_hold_drains_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && !fpu_eff) |-> (wp_en && wp_addr == hold_rd && wp_data == hold_data));

  assert_direct_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_eff && !fpu_eff && !hold_vld) |-> (wp_en && wp_addr == alu_rd && wp_data == alu_data));

  assert_stall_keeps_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (hold_vld && hold_rd == $past(hold_rd) && hold_data == $past(hold_data)));

  assert_stall_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (wp_en && wp_addr == fpu_rd));

endmodule

// File: rtl/wbf_fwd_sel.sv
module wbf_fwd_sel
  import wbf_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rf_data,
  input  logic          alu_eff,
  input  logic [AW-1:0] alu_rd,
  input  logic [DW-1:0] alu_data,
  input  logic          hold_vld,
  input  logic [AW-1:0] hold_rd,
  input  logic [DW-1:0] hold_data,
  input  logic          fpu_eff,
  input  logic [AW-1:0] fpu_rd,
  input  logic [DW-1:0] fpu_data,
  output logic [DW-1:0] opnd
);

  logic     rd_zero;
  logic     alu_hit;
  logic     hold_hit;
  logic     fpu_hit;
  fwd_src_e src;

  assign rd_zero  = (rd_addr == '0);
  assign alu_hit  = alu_eff  && (alu_rd  == rd_addr);
  assign hold_hit = hold_vld && (hold_rd == rd_addr);
  assign fpu_hit  = fpu_eff  && (fpu_rd  == rd_addr);
  assign src      = pick_src(rd_zero, alu_hit, hold_hit, fpu_hit);

  always_comb begin
    unique case (src)
      SRC_ZERO: opnd = '0;
      SRC_ALU:  opnd = alu_data;
      SRC_HOLD: opnd = hold_data;
      SRC_FPU:  opnd = fpu_data;
      default:  opnd = rf_data;
    endcase
  end

  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == '0) |-> (opnd == '0));

  assert_held_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && hold_rd == rd_addr && rd_addr != '0 && !(alu_eff && alu_rd == rd_addr))
      |-> (opnd == hold_data));

  assert_alu_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_eff && alu_rd == rd_addr) |-> (opnd == alu_data));

endmodule

// File: rtl/wbf_top.sv
module wbf_top
  import wbf_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alu_vld,
  input  logic [AW-1:0] alu_rd,
  input  logic [DW-1:0] alu_data,
  input  logic          fpu_vld,
  input  logic [AW-1:0] fpu_rd,
  input  logic [DW-1:0] fpu_data,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  input  logic [DW-1:0] rf_rdata_a,
  input  logic [DW-1:0] rf_rdata_b,
  output logic          wp_en,
  output logic [AW-1:0] wp_addr,
  output logic [DW-1:0] wp_data,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b,
  output logic          stall
);

  localparam int NRD = 2;

  logic          alu_eff;
  logic          fpu_eff;
  logic          hold_vld;
  logic [AW-1:0] hold_rd;
  logic [DW-1:0] hold_data;

  logic [NRD-1:0][AW-1:0] rd_addr_arr;
  logic [NRD-1:0][DW-1:0] rf_arr;
  logic [NRD-1:0][DW-1:0] opnd_arr;

  // Requests to register 0 carry no architectural effect and are dropped here.
  assign alu_eff = alu_vld && (alu_rd != '0);
  assign fpu_eff = fpu_vld && (fpu_rd != '0);

  assign rd_addr_arr = {rd_addr_b, rd_addr_a};
  assign rf_arr      = {rf_rdata_b, rf_rdata_a};
  assign opnd_a      = opnd_arr[0];
  assign opnd_b      = opnd_arr[1];

  wbf_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .alu_eff   (alu_eff),
    .alu_rd    (alu_rd),
    .alu_data  (alu_data),
    .fpu_eff   (fpu_eff),
    .fpu_rd    (fpu_rd),
    .fpu_data  (fpu_data),
    .wp_en     (wp_en),
    .wp_addr   (wp_addr),
    .wp_data   (wp_data),
    .stall     (stall),
    .hold_vld  (hold_vld),
    .hold_rd   (hold_rd),
    .hold_data (hold_data)
  );

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    wbf_fwd_sel #(.AW(AW), .DW(DW)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr   (rd_addr_arr[g]),
      .rf_data   (rf_arr[g]),
      .alu_eff   (alu_eff),
      .alu_rd    (alu_rd),
      .alu_data  (alu_data),
      .hold_vld  (hold_vld),
      .hold_rd   (hold_rd),
      .hold_data (hold_data),
      .fpu_eff   (fpu_eff),
      .fpu_rd    (fpu_rd),
      .fpu_data  (fpu_data),
      .opnd      (opnd_arr[g])
    );
  end

  assert_zero_dest_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wp_en |-> (wp_addr != '0));

endmodule

// File: tb/wbf_top_tb.sv
`timescale 1ns/1ps
module wbf_top_tb;

  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alu_vld = 1'b0;
  logic [AW-1:0] alu_rd = '0;
  logic [DW-1:0] alu_data = '0;
  logic          fpu_vld = 1'b0;
  logic [AW-1:0] fpu_rd = '0;
  logic [DW-1:0] fpu_data = '0;
  logic [AW-1:0] rd_addr_a = '0;
  logic [AW-1:0] rd_addr_b = '0;
  logic [DW-1:0] rf_rdata_a;
  logic [DW-1:0] rf_rdata_b;
  logic          wp_en;
  logic [AW-1:0] wp_addr;
  logic [DW-1:0] wp_data;
  logic [DW-1:0] opnd_a;
  logic [DW-1:0] opnd_b;
  logic          stall;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  wbf_top #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alu_vld(alu_vld), .alu_rd(alu_rd), .alu_data(alu_data),
    .fpu_vld(fpu_vld), .fpu_rd(fpu_rd), .fpu_data(fpu_data),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
    .wp_en(wp_en), .wp_addr(wp_addr), .wp_data(wp_data),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .stall(stall)
  );

  // Register array model: starts at 0x100 + index, written from the port.
  logic [DW-1:0] rf [32];
  initial for (int i = 0; i < 32; i++) rf[i] = 32'h100 + i;
  always @(posedge clk) if (rst_n && wp_en) rf[wp_addr] <= wp_data;
  assign rf_rdata_a = rf[rd_addr_a];
  assign rf_rdata_b = rf[rd_addr_b];

  typedef struct packed {
    logic        av;  logic [4:0] ard; logic [31:0] ad;
    logic        fv;  logic [4:0] frd; logic [31:0] fd;
    logic [4:0]  ra;  logic [4:0] rb;
    logic        ewen; logic [4:0] ewa; logic [31:0] ewd;
    logic [31:0] ea;  logic [31:0] eb;  logic estall;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    // idle read, x0 on B (R6)
    '{1'b0,5'd0,32'h0,      1'b0,5'd0,32'h0,     5'd3, 5'd0,  1'b0,5'd0,32'h0,       32'h103, 32'h0,    1'b0, 4'd6},
    // ALU alone writes now, forwarded (R3)
    '{1'b1,5'd16,32'h26be,  1'b0,5'd0,32'h0,     5'd16,5'd5,  1'b1,5'd16,32'h26be,   32'h26be,32'h105,  1'b0, 4'd3},
    '{1'b0,5'd0,32'h0,      1'b0,5'd0,32'h0,     5'd16,5'd2,  1'b0,5'd0,32'h0,       32'h26be,32'h102,  1'b0, 4'd3},
    // collision: FPU wins (R1), ALU forwarded current
    '{1'b1,5'd16,32'h3000,  1'b1,5'd4,32'haaaa,  5'd16,5'd4,  1'b1,5'd4,32'haaaa,    32'h3000,32'haaaa, 1'b0, 4'd1},
    // jump base reads held value while it drains (R4, R2)
    '{1'b0,5'd0,32'h0,      1'b0,5'd0,32'h0,     5'd16,5'd4,  1'b1,5'd16,32'h3000,   32'h3000,32'haaaa, 1'b0, 4'd4},
    '{1'b0,5'd0,32'h0,      1'b0,5'd0,32'h0,     5'd16,5'd0,  1'b0,5'd0,32'h0,       32'h3000,32'h0,    1'b0, 4'd2},
    // collision fills hold
    '{1'b1,5'd7,32'h77,     1'b1,5'd8,32'h88,    5'd7, 5'd8,  1'b1,5'd8,32'h88,      32'h77,  32'h88,   1'b0, 4'd1},
    // full hold + FPU + ALU: stall (R7), current ALU forwarded first (R5)
    '{1'b1,5'd7,32'h99,     1'b1,5'd9,32'h9a,    5'd7, 5'd9,  1'b1,5'd9,32'h9a,      32'h99,  32'h9a,   1'b1, 4'd7},
    // ALU re-presents; older held entry drains first (R8)
    '{1'b1,5'd7,32'h99,     1'b0,5'd0,32'h0,     5'd7, 5'd9,  1'b1,5'd7,32'h77,      32'h99,  32'h9a,   1'b0, 4'd8},
    '{1'b0,5'd0,32'h0,      1'b0,5'd0,32'h0,     5'd7, 5'd7,  1'b1,5'd7,32'h99,      32'h99,  32'h99,   1'b0, 4'd8},
    // newer value is final (R8)
    '{1'b0,5'd0,32'h0,      1'b0,5'd0,32'h0,     5'd7, 5'd16, 1'b0,5'd0,32'h0,       32'h99,  32'h3000, 1'b0, 4'd8},
    '{1'b1,5'd10,32'ha1,    1'b1,5'd11,32'hb1,   5'd10,5'd11, 1'b1,5'd11,32'hb1,     32'ha1,  32'hb1,   1'b0, 4'd1},
    // FPU keeps port, held beats FPU in forwarding (R5, R2)
    '{1'b0,5'd0,32'h0,      1'b1,5'd10,32'hc1,   5'd10,5'd11, 1'b1,5'd10,32'hc1,     32'ha1,  32'hb1,   1'b0, 4'd5},
    '{1'b0,5'd0,32'h0,      1'b0,5'd0,32'h0,     5'd10,5'd3,  1'b1,5'd10,32'ha1,     32'ha1,  32'h103,  1'b0, 4'd2},
    '{1'b0,5'd0,32'h0,      1'b0,5'd0,32'h0,     5'd10,5'd0,  1'b0,5'd0,32'h0,       32'ha1,  32'h0,    1'b0, 4'd5},
    // destination 0 dropped (R6)
    '{1'b1,5'd0,32'h55,     1'b0,5'd0,32'h0,     5'd0, 5'd0,  1'b0,5'd0,32'h0,       32'h0,   32'h0,    1'b0, 4'd6},
    '{1'b1,5'd0,32'h55,     1'b1,5'd12,32'hc2,   5'd12,5'd0,  1'b1,5'd12,32'hc2,     32'hc2,  32'h0,    1'b0, 4'd6},
    '{1'b0,5'd0,32'h0,      1'b0,5'd0,32'h0,     5'd12,5'd3,  1'b0,5'd0,32'h0,       32'hc2,  32'h103,  1'b0, 4'd6},
    '{1'b1,5'd13,32'hd1,    1'b1,5'd0,32'h66,    5'd13,5'd0,  1'b1,5'd13,32'hd1,     32'hd1,  32'h0,    1'b0, 4'd6},
    '{1'b0,5'd0,32'h0,      1'b0,5'd0,32'h0,     5'd13,5'd0,  1'b0,5'd0,32'h0,       32'hd1,  32'h0,    1'b0, 4'd6}
  };

  function automatic string req_name(input int n);
    case (n)
      1: return "R1"; 2: return "R2"; 3: return "R3";
      4: return "R4"; 5: return "R5"; 6: return "R6";
      7: return "R7"; 8: return "R8"; 9: return "R9";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    alu_vld = 1'b0; alu_rd = '0; alu_data = '0;
    fpu_vld = 1'b0; fpu_rd = '0; fpu_data = '0;
  endtask

  initial begin
    drive_idle();
    rd_addr_a = 5'd1; rd_addr_b = 5'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R9: reset state
    chk("R9", "wp_en after reset", {31'b0, wp_en}, 32'h0);
    chk("R9", "stall after reset", {31'b0, stall}, 32'h0);
    chk("R9", "opnd_a after reset", opnd_a, 32'h101);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      alu_vld = VECS[v].av; alu_rd = VECS[v].ard; alu_data = VECS[v].ad;
      fpu_vld = VECS[v].fv; fpu_rd = VECS[v].frd; fpu_data = VECS[v].fd;
      rd_addr_a = VECS[v].ra; rd_addr_b = VECS[v].rb;
      #2;
      chk(req_name(VECS[v].req), $sformatf("v%0d wp_en", v), {31'b0, wp_en}, {31'b0, VECS[v].ewen});
      if (VECS[v].ewen) begin
        chk(req_name(VECS[v].req), $sformatf("v%0d wp_addr", v), {27'b0, wp_addr}, {27'b0, VECS[v].ewa});
        chk(req_name(VECS[v].req), $sformatf("v%0d wp_data", v), wp_data, VECS[v].ewd);
      end
      chk(req_name(VECS[v].req), $sformatf("v%0d opnd_a", v), opnd_a, VECS[v].ea);
      chk(req_name(VECS[v].req), $sformatf("v%0d opnd_b", v), opnd_b, VECS[v].eb);
      chk(req_name(VECS[v].req), $sformatf("v%0d stall", v), {31'b0, stall}, {31'b0, VECS[v].estall});
    end

    // R9: reset while the hold register is full discards the held entry
    @(negedge clk);
    alu_vld = 1'b1; alu_rd = 5'd14; alu_data = 32'he1;
    fpu_vld = 1'b1; fpu_rd = 5'd15; fpu_data = 32'hf1;
    rd_addr_a = 5'd14; rd_addr_b = 5'd15;
    @(negedge clk);
    drive_idle();
    rst_n = 1'b0;
    #2;
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R9", "wp_en after mid-hold reset", {31'b0, wp_en}, 32'h0);
    chk("R9", "opnd_a after mid-hold reset", opnd_a, 32'h10e);
    chk("R9", "opnd_b after mid-hold reset", opnd_b, 32'hf1);

    // R2: FPU holds the port for several cycles; deferred ALU waits, then drains
    @(negedge clk);
    alu_vld = 1'b1; alu_rd = 5'd20; alu_data = 32'h2020;
    fpu_vld = 1'b1; fpu_rd = 5'd21; fpu_data = 32'h2121;
    rd_addr_a = 5'd20; rd_addr_b = 5'd21;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      alu_vld = 1'b0; alu_rd = '0; alu_data = '0;
      fpu_vld = 1'b1; fpu_rd = 5'd22; fpu_data = 32'h2200 + k;
      #2;
      chk("R2", "port stays with FPU", {27'b0, wp_addr}, 32'd22);
      chk("R4", "held value forwarded while waiting", opnd_a, 32'h2020);
    end
    @(negedge clk);
    drive_idle();
    #2;
    chk("R2", "deferred write address", {27'b0, wp_addr}, 32'd20);
    chk("R2", "deferred write data", wp_data, 32'h2020);
    @(negedge clk);
    #2;
    chk("R2", "register holds deferred value", opnd_a, 32'h2020);
    chk("R2", "port idle after drain", {31'b0, wp_en}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule